// File: doc/BRIEF.md
# DMA Channel Enable Control Register

This block holds the on/off state of each channel of a four-channel DMA controller as one software-visible register. A bus write sets the new enable values in the low bits of the data word. It also sets a mask of write-enable bits in the upper half of the low word. Only the channels whose mask bit is set take the new value. Software can therefore start or stop one channel without reading the register first and writing it back.

Each channel engine sends a one-cycle done pulse after the final transfer of its job has reached the destination. The pulse clears that channel's enable bit. Software polls the register and sees the bit drop to learn that the job has finished. The enable vector goes straight to the channel engines from a register.

Top module: `dma_chan_enable`

## Requirements
- R1: While reset is high, and on the first cycle after it, chan_en is 0 and bus_rdata is 0x00000000.
- R2: A write at address 0x3A0 with bit 8+n of bus_wdata set loads bus_wdata bit n into chan_en[n] (1 = enabled, 0 = disabled). The new value is visible on the cycle after the write.
- R3: A write at address 0x3A0 leaves chan_en[n] unchanged when bit 8+n of bus_wdata is 0. For example, writing 0x101 enables channel 0 only and leaves channels 1 to 3 unchanged.
- R4: A one-cycle pulse on chan_done[n] clears chan_en[n] on the next cycle.
- R5: If chan_done[n] pulses in the same cycle as an accepted software write with bit 8+n set, the software value wins.
- R6: A write to any address other than 0x3A0 changes no enable bit.
- R7: A read at 0x3A0 returns the enable bits on bus_rdata[3:0] one cycle later. Bits 31:4, including the write-enable positions 11:8, always read 0. A read at any other address, or no read at all, gives 0x00000000 on the next cycle.
- R8: A read has no side effect on chan_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data: values in bits 3:0, write-enable mask in bits 11:8 |
| bus_rdata | output | 32 | Registered read data |
| chan_done | input | 4 | Per-channel completion pulse from the channel engines |
| chan_en | output | 4 | Per-channel enable, registered |

## Verification
Bound properties check on every cycle that a masked write loads exactly the selected channels. They also check that an unselected channel changes only through its done pulse, and that a done pulse clears a channel unless a software write targets it. The read data must mirror the prior cycle's enables, and its upper bits must stay zero. Some behaviours only the bench's scenarios can show: that the example word 0x101 leaves the other channels alone, that a write to a neighbouring address is ignored, and that a polling loop sees a bit fall after a done pulse. The same holds for the collision cases in both directions, where software sets or clears a channel in the cycle its done pulse arrives.

// File: rtl/dmaen_pkg.sv
package dmaen_pkg;
  localparam int unsigned DEF_NUM_CH  = 4;
  localparam int unsigned DEF_ADDR_W  = 12;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_MASK_LSB = 8;
  localparam logic [11:0] DEF_OFFSET  = 12'h3A0;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_SW     = 2'd1,
    ACT_HW_CLR = 2'd2
  } en_action_e;
endpackage

// File: rtl/dmaen_decode.sv
module dmaen_decode #(
  parameter int unsigned NUM_CH   = dmaen_pkg::DEF_NUM_CH,
  parameter int unsigned ADDR_W   = dmaen_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W   = dmaen_pkg::DEF_DATA_W,
  parameter int unsigned MASK_LSB = dmaen_pkg::DEF_MASK_LSB,
  parameter logic [ADDR_W-1:0] OFFSET = dmaen_pkg::DEF_OFFSET
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [NUM_CH-1:0] sw_sel,
  output logic [NUM_CH-1:0] sw_val,
  output logic              rd_hit
);
  logic addr_hit;
  logic unused_wdata;

  assign addr_hit     = (bus_addr == OFFSET);
  assign rd_hit       = bus_re && addr_hit;
  assign unused_wdata = ^bus_wdata;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_sel
    assign sw_sel[n] = bus_we && addr_hit && bus_wdata[MASK_LSB+n];
    assign sw_val[n] = bus_wdata[n];
  end
endmodule

// File: rtl/dmaen_cell.sv
module dmaen_cell (
  input  logic clk,
  input  logic rst,
  input  logic sw_sel,
  input  logic sw_val,
  input  logic hw_done,
  output logic en_q
);
  import dmaen_pkg::*;

  en_action_e act;

  always_comb begin
    if (sw_sel)       act = ACT_SW;
    else if (hw_done) act = ACT_HW_CLR;
    else              act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else begin
      case (act)
        ACT_SW:     en_q <= sw_val;
        ACT_HW_CLR: en_q <= 1'b0;
        default:    en_q <= en_q;
      endcase
    end
  end
endmodule

// File: rtl/dmaen_rdport.sv
module dmaen_rdport #(
  parameter int unsigned NUM_CH = dmaen_pkg::DEF_NUM_CH,
  parameter int unsigned DATA_W = dmaen_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic [NUM_CH-1:0] en,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - NUM_CH;

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= {{PAD_W{1'b0}}, en};
    else             rdata <= '0;
  end
endmodule

// File: rtl/dma_chan_enable.sv
module dma_chan_enable #(
  parameter int unsigned NUM_CH   = dmaen_pkg::DEF_NUM_CH,
  parameter int unsigned ADDR_W   = dmaen_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W   = dmaen_pkg::DEF_DATA_W,
  parameter int unsigned MASK_LSB = dmaen_pkg::DEF_MASK_LSB,
  parameter logic [ADDR_W-1:0] OFFSET = dmaen_pkg::DEF_OFFSET
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] chan_done,
  output logic [NUM_CH-1:0] chan_en
);
  logic [NUM_CH-1:0] sw_sel;
  logic [NUM_CH-1:0] sw_val;
  logic              rd_hit;

  dmaen_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MASK_LSB(MASK_LSB), .OFFSET(OFFSET)
  ) u_decode (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_wdata(bus_wdata),
    .sw_sel   (sw_sel),
    .sw_val   (sw_val),
    .rd_hit   (rd_hit)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_cell
    dmaen_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .sw_sel (sw_sel[n]),
      .sw_val (sw_val[n]),
      .hw_done(chan_done[n]),
      .en_q   (chan_en[n])
    );
  end

  dmaen_rdport #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rdport (
    .clk   (clk),
    .rst   (rst),
    .rd_hit(rd_hit),
    .en    (chan_en),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/dmaen_checker.sv
module dmaen_checker #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MASK_LSB = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h3A0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] chan_done,
  input logic [NUM_CH-1:0] chan_en
);
  AST_UPPER_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NUM_CH] == '0); // R7

  AST_READ_MIRRORS: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == OFFSET) |=> bus_rdata[NUM_CH-1:0] == $past(chan_en)); // R7

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    AST_SW_LOADS: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == OFFSET && bus_wdata[MASK_LSB+n])
      |=> chan_en[n] == $past(bus_wdata[n])); // R2

    AST_UNSELECTED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!(bus_we && bus_addr == OFFSET && bus_wdata[MASK_LSB+n]) && !chan_done[n])
      |=> $stable(chan_en[n])); // R3

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (chan_done[n] && !(bus_we && bus_addr == OFFSET && bus_wdata[MASK_LSB+n]))
      |=> !chan_en[n]); // R4
  end
endmodule

bind dma_chan_enable dmaen_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .MASK_LSB(MASK_LSB), .OFFSET(OFFSET)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .chan_done(chan_done), .chan_en(chan_en)
);

// File: tb/dma_chan_enable_bench.sv
`timescale 1ns/1ps
module dma_chan_enable_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  chan_done;
  logic [3:0]  chan_en;

  int checks = 0;
  int fails  = 0;
  bit model_on = 1'b0;

  // behavioural reference state
  int mdl_en [4];
  int mdl_rd;

  always #2 clk = ~clk;

  dma_chan_enable u_dma_chan_enable (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_done(chan_done), .chan_en(chan_en)
  );

  function automatic int mdl_vec();
    int v = 0;
    for (int i = 0; i < 4; i++) v += mdl_en[i] << i;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) mdl_en[i] = 0;
      mdl_rd = 0;
    end else begin
      mdl_rd = (bus_re && bus_addr == 12'h3A0) ? mdl_vec() : 0;
      for (int i = 0; i < 4; i++) begin
        if (bus_we && bus_addr == 12'h3A0 && bus_wdata[8+i]) mdl_en[i] = int'(bus_wdata[i]);
        else if (chan_done[i]) mdl_en[i] = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model (R2 R3 R4 R5 R6 R7)
  always @(negedge clk) begin
    if (model_on) begin
      chk("R2/R3/R4 model chan_en", int'(chan_en), mdl_vec());
      chk("R7 model bus_rdata", int'(bus_rdata), mdl_rd);
    end
  end

  task automatic idle();
    bus_we = 0; bus_re = 0; chan_done = '0; bus_addr = 12'h3A0; bus_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] dn);
    bus_addr = a; bus_wdata = d; bus_we = 1; chan_done = dn;
    step();
  endtask

  task automatic rd(input logic [11:0] a);
    bus_addr = a; bus_re = 1;
    step();
  endtask

  task automatic done(input logic [3:0] dn);
    chan_done = dn;
    step();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset chan_en", int'(chan_en), 0);
    chk("R1 reset rdata", int'(bus_rdata), 0);
    rst = 0;
    step();
    model_on = 1;
    chk("R1 first cycle chan_en", int'(chan_en), 0);

    wr(12'h3A0, 32'h0000_0101, 4'h0);
    chk("R3 0x101 enables ch0 only", int'(chan_en), 4'b0001);
    wr(12'h3A0, 32'h0000_000F, 4'h0);
    chk("R3 no mask bits keeps value", int'(chan_en), 4'b0001);
    wr(12'h3A0, 32'h0000_0E0E, 4'h0);
    chk("R2 masked set ch1..3", int'(chan_en), 4'b1111);
    wr(12'h3A4, 32'h0000_0F00, 4'h0);
    chk("R6 other address ignored", int'(chan_en), 4'b1111);
    wr(12'h3A0, 32'h0000_0400, 4'h0);
    chk("R2 masked clear ch2", int'(chan_en), 4'b1011);

    rd(12'h3A0);
    chk("R7 read value", int'(bus_rdata), 32'h0000_000B);
    chk("R8 read no side effect", int'(chan_en), 4'b1011);
    rd(12'h3A4);
    chk("R7 other address reads zero", int'(bus_rdata), 0);
    wr(12'h3A0, 32'hFFFF_FFFF, 4'h0);
    rd(12'h3A0);
    chk("R7 mask bits read zero", int'(bus_rdata), 32'h0000_000F);

    done(4'b0100);
    chk("R4 done clears ch2", int'(chan_en), 4'b1011);
    done(4'b1000);
    rd(12'h3A0);
    chk("R4 poll sees ch3 finished", int'(bus_rdata), 32'h0000_0003);

    wr(12'h3A0, 32'h0000_0101, 4'b0001);
    chk("R5 write set beats done", int'(chan_en), 4'b0011);
    wr(12'h3A0, 32'h0000_0200, 4'b0011);
    chk("R5 write clear with done, R4 ch0 cleared", int'(chan_en), 4'b0000);
    wr(12'h3A0, 32'h0000_0F0F, 4'b0000);
    wr(12'h3A8, 32'h0000_0F00, 4'b0110);
    chk("R6 stray write + R4 done", int'(chan_en), 4'b1001);

    rst = 1;
    step();
    model_on = 0;
    chk("R1 reset after activity", int'(chan_en), 0);
    rst = 0;
    repeat (2) step();
    finish_run();
  end
endmodule